// File: doc/BRIEF.md
# Strap-Pin Configuration Controller

This block configures a multi-port Ethernet PHY that runs without a management host. Four asynchronous configuration pins feed it: crossover select, link force, 34-pattern force and 4B/5B bypass. A pin can mean one thing while reset is held and something else after reset. The block captures the reset-time meaning in strap flops. After reset it switches the pins to live control, according to what was captured. It also merges pin levels with software-written bits in two registers and drives the resulting effective control values.

Software writes through a simple one-cycle port. The control register is at address 0 and the status/configuration register is at address 17. A combinational read port returns the effective values of those registers, with ORed and forced bits applied. Every pin passes through a two-flop synchronizer. The strap flops load on every clock edge while `rst_n` is low, so the value held after reset is the one sampled at the last edge of the reset interval.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: A pin level reaches the outputs two rising clock edges after it is applied. After one edge the outputs still show the old level.
- R2: If the crossover pin is high when reset ends, `auto_xover_o` is 1 until the next reset. While it is 1, `xover_mode_o` is 0 whatever the pin does.
- R3: If automatic crossover was not strapped, `xover_mode_o` follows the crossover pin after reset: 1 means crossover and 0 means straight-through.
- R4: If the link-force pin is high when reset ends, then after reset `aneg_en_o` is 0, `link_good_o` is 1 and `link_integ_o` is 1. Reads show bit 12 of address 0 as 0, and bits 11 and 1 of address 17 as 1.
- R5: If the link-force pin is low when reset ends, speed (address 0 bit 13, 1 means 100 Mbps), auto-negotiation enable (address 0 bit 12) and link integrity (address 17 bit 1) come from the software bits. Reset loads address 0 with 0x3000 and address 17 with 0x0000.
- R6: If the link-force pin was strapped high, `speed100_o` and address 0 bit 13 follow the live link-force pin: 1 means 100 Mbps and 0 means 10 Mbps.
- R7: `link_good_o`, and address 17 bit 11 on reads, equal the OR of the live link-force pin and the software bit 11.
- R8: `pat34_o`, and address 17 bit 12 on reads, equal the OR of the 34-pattern pin and the software bit 12.
- R9: `bypass_o` is 1 only after reset, only while the bypass pin is high, and only if that pin was low when reset ended. If the pin was high when reset ended, `strap_err_o` is 1 and `bypass_o` stays 0 until the next reset.
- R10: Software writes to forced bits are stored but have no effect while the force is active. The other bits of the same write read back as written. Writes to addresses other than 0 and 17 are ignored, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous; the strap sampling window |
| pin_xover_i | input | 1 | Crossover pin, asynchronous |
| pin_lnkfrc_i | input | 1 | Link-force pin, asynchronous |
| pin_pat34_i | input | 1 | 34-pattern force pin, asynchronous |
| pin_bypass_i | input | 1 | 4B/5B bypass pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 16 | Effective value of the addressed register |
| xover_mode_o | output | 1 | 1 means crossover, 0 means straight-through |
| auto_xover_o | output | 1 | Automatic crossover enabled |
| speed100_o | output | 1 | 1 means 100 Mbps, 0 means 10 Mbps |
| aneg_en_o | output | 1 | Auto-negotiation enable |
| link_good_o | output | 1 | Forced good link |
| link_integ_o | output | 1 | Link integrity forced |
| pat34_o | output | 1 | Force 34 transmit pattern |
| bypass_o | output | 1 | 4B/5B bypass active |
| strap_err_o | output | 1 | Bypass pin was high when reset ended |

## Verification
The bench targets the dual role of the pins.

- It changes the crossover and link-force pins after reset under both strap outcomes. A design that kept reading straps live would let `auto_xover_o` or the forced link bits drop.
- It checks the output one edge after a pin change. A design with the wrong synchronizer depth shows the new level too early or too late.
- It writes software values into forced bit positions and confirms that reads still show the forced levels while the unforced bits of the same write are stored.
- It holds the bypass pin high through reset and after it. A design that dropped the error flag would let bypass turn on.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 5;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'd0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 5'd17;
  localparam int B_SPEED   = 13;
  localparam int B_ANEG    = 12;
  localparam int B_GOOD    = 11;
  localparam int B_PAT34   = 12;
  localparam int B_INTEG   = 1;
  localparam logic [REG_W-1:0] CTRL_RST = 16'h3000;
  localparam logic [REG_W-1:0] STAT_RST = 16'h0000;

  typedef struct packed {
    logic auto_x;
    logic frc_lnk;
    logic bp_err;
  } strap_t;

  function automatic logic [REG_W-1:0] merge_ctrl(input logic [REG_W-1:0] sw,
                                                  input logic frc, input logic spd_pin);
    logic [REG_W-1:0] r;
    r = sw;
    if (frc) begin
      r[B_ANEG]  = 1'b0;
      r[B_SPEED] = spd_pin;
    end
    return r;
  endfunction

  function automatic logic [REG_W-1:0] merge_stat(input logic [REG_W-1:0] sw,
                                                  input logic frc, input logic lnk_pin,
                                                  input logic p34_pin);
    logic [REG_W-1:0] r;
    r = sw;
    r[B_GOOD]  = sw[B_GOOD] | lnk_pin | frc;
    r[B_INTEG] = sw[B_INTEG] | frc;
    r[B_PAT34] = sw[B_PAT34] | p34_pin;
    return r;
  endfunction

  function automatic logic xover_sel(input logic auto_en, input logic pin);
    return auto_en ? 1'b0 : pin;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      meta[i] <= d[i];
      q[i]    <= meta[i];
    end
  end

  // R1
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q == $past(d, 2));
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   s_xover,
  input  logic   s_lnkfrc,
  input  logic   s_bypass,
  output strap_t st
);
  logic was_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st.auto_x  <= s_xover;
      st.frc_lnk <= s_lnkfrc;
      st.bp_err  <= s_bypass;
    end
    was_run <= rst_n;
  end

  // R2 R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    was_run |-> $stable(st));
endmodule

// File: rtl/strap_regs.sv
module strap_regs
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  strap_t            st,
  input  logic              s_lnkfrc,
  input  logic              s_pat34,
  output logic [REG_W-1:0]  ctrl_eff,
  output logic [REG_W-1:0]  stat_eff,
  output logic [REG_W-1:0]  rd_data
);
  logic [REG_W-1:0] ctrl_sw, stat_sw;
  logic wr_ctrl, wr_stat;

  assign wr_ctrl = wr_en && (wr_addr == CTRL_ADDR);
  assign wr_stat = wr_en && (wr_addr == STAT_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_sw <= CTRL_RST;
      stat_sw <= STAT_RST;
    end else begin
      if (wr_ctrl) ctrl_sw <= wr_data;
      if (wr_stat) stat_sw <= wr_data;
    end
  end

  assign ctrl_eff = merge_ctrl(ctrl_sw, st.frc_lnk, s_lnkfrc);
  assign stat_eff = merge_stat(stat_sw, st.frc_lnk, s_lnkfrc, s_pat34);

  always_comb begin
    if (rd_addr == CTRL_ADDR)      rd_data = ctrl_eff;
    else if (rd_addr == STAT_ADDR) rd_data = stat_eff;
    else                           rd_data = '0;
  end

  // R10
  forced_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.frc_lnk && wr_ctrl) |=> (ctrl_eff[B_ANEG] == 1'b0));
  // R7
  good_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_lnkfrc |-> stat_eff[B_GOOD]);
  // R4
  frc_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.frc_lnk |-> (stat_eff[B_GOOD] && stat_eff[B_INTEG] && !ctrl_eff[B_ANEG]));
endmodule

// File: rtl/strap_cfg_ctrl.sv
module strap_cfg_ctrl
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_xover_i,
  input  logic              pin_lnkfrc_i,
  input  logic              pin_pat34_i,
  input  logic              pin_bypass_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              xover_mode_o,
  output logic              auto_xover_o,
  output logic              speed100_o,
  output logic              aneg_en_o,
  output logic              link_good_o,
  output logic              link_integ_o,
  output logic              pat34_o,
  output logic              bypass_o,
  output logic              strap_err_o
);
  localparam int NPIN = 4;

  logic [NPIN-1:0] pins_raw, pins_s;
  logic s_xover, s_lnkfrc, s_pat34, s_bypass;
  strap_t st;
  logic [REG_W-1:0] ctrl_eff, stat_eff;

  assign pins_raw = {pin_bypass_i, pin_pat34_i, pin_lnkfrc_i, pin_xover_i};
  assign {s_bypass, s_pat34, s_lnkfrc, s_xover} = pins_s;

  strap_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

  strap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .s_xover(s_xover), .s_lnkfrc(s_lnkfrc),
    .s_bypass(s_bypass), .st(st));

  strap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .rd_addr(rd_addr_i), .st(st), .s_lnkfrc(s_lnkfrc),
    .s_pat34(s_pat34), .ctrl_eff(ctrl_eff), .stat_eff(stat_eff), .rd_data(rd_data_o));

  assign auto_xover_o = st.auto_x;
  assign xover_mode_o = xover_sel(st.auto_x, s_xover);
  assign speed100_o   = ctrl_eff[B_SPEED];
  assign aneg_en_o    = ctrl_eff[B_ANEG];
  assign link_good_o  = stat_eff[B_GOOD];
  assign link_integ_o = stat_eff[B_INTEG];
  assign pat34_o      = stat_eff[B_PAT34];
  assign bypass_o     = rst_n & s_bypass & ~st.bp_err;
  assign strap_err_o  = st.bp_err;

  // R9
  bypass_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_err_o |-> !bypass_o);
  // R3
  manual_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_xover_o |-> (xover_mode_o == s_xover));
  // R2
  auto_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_xover_o |-> !xover_mode_o);
  // R6
  speed_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.frc_lnk |-> (speed100_o == s_lnkfrc));
endmodule

// File: tb/strap_cfg_ctrl_tb.sv
module strap_cfg_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic px = 0, pl = 0, pp = 0, pb = 0;
  logic wr_en = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic xov, autox, spd, aneg, good, integ, pat, byp, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_cfg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pin_xover_i(px), .pin_lnkfrc_i(pl),
    .pin_pat34_i(pp), .pin_bypass_i(pb), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .xover_mode_o(xov), .auto_xover_o(autox), .speed100_o(spd), .aneg_en_o(aneg),
    .link_good_o(good), .link_integ_o(integ), .pat34_o(pat), .bypass_o(byp),
    .strap_err_o(err));

  typedef struct {
    string       tag;
    bit          is_rd;
    logic [15:0] exp;
  } item_t;
  item_t sbq[$];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench model state
  bit m_auto, m_frc, m_err;
  logic [15:0] m_c, m_s;

  function automatic logic [15:0] exp_obs();
    logic [8:0] v;
    v[0] = m_auto ? 1'b0 : px;
    v[1] = m_auto;
    v[2] = m_frc ? pl : m_c[13];
    v[3] = m_frc ? 1'b0 : m_c[12];
    v[4] = pl | m_s[11] | m_frc;
    v[5] = m_s[1] | m_frc;
    v[6] = pp | m_s[12];
    v[7] = pb & ~m_err;
    v[8] = m_err;
    return {7'd0, v};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    logic [15:0] r;
    if (a == 5'd0) begin
      r = m_c;
      if (m_frc) begin r[12] = 1'b0; r[13] = pl; end
    end else if (a == 5'd17) begin
      r = m_s;
      r[11] = m_s[11] | pl | m_frc;
      r[1]  = m_s[1] | m_frc;
      r[12] = m_s[12] | pp;
    end else r = 16'd0;
    return r;
  endfunction

  // monitor: pops one item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = sbq.pop_front();
        got = it.is_rd ? rd_data : {7'd0, err, byp, pat, integ, good, aneg, spd, autox, xov};
        n_chk++;
        if (got !== it.exp) begin
          n_err++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input string tag, input bit is_rd, input logic [15:0] e);
    item_t it;
    it.tag = tag; it.is_rd = is_rd; it.exp = e;
    sbq.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic chk_obs(input string tag);
    push(tag, 1'b0, exp_obs());
  endtask

  task automatic chk_rd(input string tag, input logic [4:0] a);
    rd_addr = a;
    push(tag, 1'b1, exp_rd(a));
  endtask

  task automatic do_reset(input logic x, input logic l, input logic b);
    rst_n = 0; px = x; pl = l; pp = 0; pb = b;
    wait_cyc(5);
    rst_n = 1;
    m_auto = x; m_frc = l; m_err = b; m_c = 16'h3000; m_s = 16'h0000;
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    wait_cyc(1);
    wr_en = 0;
    if (a == 5'd0) m_c = d;
    else if (a == 5'd17) m_s = d;
  endtask

  task automatic set_pins(input logic x, input logic l, input logic p, input logic b);
    px = x; pl = l; pp = p; pb = b;
    wait_cyc(3);
  endtask

  initial begin
    logic [15:0] old;
    do_reset(0, 0, 0);
    chk_obs("R5 reset outputs");
    chk_rd("R5 reset ctrl", 5'd0);
    chk_rd("R5 reset stat", 5'd17);
    // R1 latency: one edge after change shows old value
    old = exp_obs();
    @(posedge clk); #1;
    px = 1;
    wait_cyc(1);
    push("R1 one edge old", 1'b0, old);
    chk_obs("R1 R3 two edges new");
    set_pins(0, 0, 0, 0);
    chk_obs("R3 straight");
    set_pins(0, 0, 1, 0);
    chk_obs("R8 pin pattern");
    chk_rd("R8 read stat", 5'd17);
    set_pins(0, 0, 0, 0);
    reg_wr(5'd17, 16'h1002);
    chk_obs("R8 R5 sw pattern integ");
    set_pins(0, 1, 0, 0);
    chk_obs("R7 pin good");
    chk_rd("R7 read stat", 5'd17);
    set_pins(0, 0, 0, 0);
    reg_wr(5'd0, 16'h0001);
    chk_obs("R5 sw speed aneg");
    chk_rd("R5 read ctrl", 5'd0);
    reg_wr(5'd5, 16'hFFFF);
    chk_rd("R10 other addr", 5'd5);
    chk_obs("R10 other addr no effect");
    set_pins(0, 0, 0, 1);
    chk_obs("R9 bypass live");
    set_pins(0, 0, 0, 0);
    // strap crossover and link force
    do_reset(1, 1, 0);
    chk_obs("R2 R4 strapped");
    chk_rd("R4 read ctrl", 5'd0);
    chk_rd("R4 read stat", 5'd17);
    set_pins(0, 0, 0, 0);
    chk_obs("R2 R6 after pins low");
    chk_rd("R6 read ctrl", 5'd0);
    set_pins(1, 1, 0, 0);
    chk_obs("R2 R6 pins high");
    reg_wr(5'd0, 16'h3001);
    set_pins(1, 0, 0, 0);
    chk_obs("R10 masked write");
    chk_rd("R10 read masked", 5'd0);
    reg_wr(5'd17, 16'h0000);
    chk_rd("R10 R4 stat forced", 5'd17);
    // bypass strap error
    do_reset(0, 0, 1);
    chk_obs("R9 strap error");
    wait_cyc(4);
    chk_obs("R9 bypass held off");
    set_pins(0, 0, 0, 0);
    set_pins(0, 0, 0, 1);
    chk_obs("R9 still off");
    do_reset(0, 0, 0);
    set_pins(0, 0, 0, 1);
    chk_obs("R9 cleared by reset");
    wait_cyc(2);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule